// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is the slave side of a byte-wide serial EEPROM. It sits behind a four-wire SPI port (select, clock, data in, data out) and works in clock modes 0 and 3. The pins are brought into the system clock domain and edge-detected. An 8-bit command byte then selects one of six operations: latch a write permission, drop that permission, read the status byte, write the status byte, read the array sequentially, or write up to one page. The storage is an on-chip register array that comes out of reset erased to 0xFF.

A write is held in a page buffer. It is committed only when the host releases select exactly after a whole data byte, and only after a self-timed cycle counter expires. While that counter runs, the busy flag is set and only status reads are served. The decision whether the array or the status byte may be written is made elsewhere and arrives on two enable inputs. A third enable from a pause block freezes the serial engine and releases the data output.

Top module: `eep_spi_slave`

## Requirements
- R1: After reset the array reads 0xFF, the status byte reads 0x00 and `so_oe` is low. Clock edges seen while select has not yet gone from high to low since reset are ignored, and a command clocked in that way has no effect.
- R2: Command bytes arrive MSB first on rising SCK. The codes are 0x06 (set write permission), 0x04 (clear write permission), 0x05 (read status), 0x01 (write status), 0x03 (read array) and 0x02 (write array). Any other code makes the rest of the transaction, up to select high, be ignored.
- R3: The status byte holds the busy flag in bit 0, the write permission in bit 1, a 2-bit protect field in bits 3:2 and a lock-enable bit in bit 7. Other bits read 0. Code 0x06 sets bit 1 only if select rises right after its eighth bit; any further clock edge cancels it. Code 0x04 clears bit 1.
- R4: A read or write command is followed by a 16-bit address, of which only the low ADDR_W bits are used. Read data leaves on `so` MSB first, each bit changing after a falling SCK edge. The address increments after every byte and wraps from the top of the array to 0, in both clock modes.
- R5: Write data fills a page buffer of 2^PAGE_W bytes. The byte position wraps inside the page addressed by the command, so later bytes overwrite earlier ones.
- R6: A write starts only if select rises on a byte boundary after at least one full data byte. Select rising in the middle of a byte, or before any data byte, leaves the array unchanged and starts no cycle.
- R7: An array or status write with the permission bit clear is ignored. The permission bit is cleared when a write cycle completes.
- R8: A started write keeps the busy bit at 1 for WC_CYCLES clocks and commits at the end. Meanwhile every command except status read is ignored.
- R9: A status write takes bits 7, 3 and 2 of its data byte, commits them at the end of the cycle, and is refused (permission kept, no cycle) while `sr_wr_ok` is low.
- R10: An array write while `arr_wr_ok` is low starts no cycle and leaves the array unchanged.
- R11: While `xfer_en` is low, SCK edges are ignored and `so_oe` is low. When it returns high, the transfer resumes at the same bit.
- R12: `so_oe` is low while select is high and high during the data phase of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data into the block |
| xfer_en | input | 1 | Pause gate from the pause block; low freezes the transfer |
| sr_wr_ok | input | 1 | Status byte may be written (from protection logic) |
| arr_wr_ok | input | 1 | Array may be written (from protection logic) |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |

## Verification
The bench builds the block with ADDR_W=8, PAGE_W=3 and WC_CYCLES=1500. The 256-byte array makes the top-to-zero read wrap cheap to reach. The 8-byte page lets a ten-byte burst wrap inside its page and overwrite two bytes. The cycle length is long enough that a status read and a full rejected write command both fit inside one busy window, which exposes the command lockout and the live busy bit.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_RDARR,
        PH_RDSTAT,
        PH_WRARR,
        PH_WRSTAT,
        PH_WENDONE,
        PH_SKIP
    } phase_e;

    typedef enum logic {
        JOB_ARRAY,
        JOB_STATUS
    } job_e;

    typedef struct packed {
        logic       lock_en;
        logic [1:0] prot;
    } cfg_t;

    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sck_rise;
        logic sck_fall;
        logic si;
    } pin_ev_t;

    function automatic logic [7:0] status_byte(cfg_t c, logic wel, logic busy);
        return {c.lock_en, 3'b000, c.prot, wel, busy};
    endfunction

    function automatic logic is_read_phase(phase_e p);
        return (p == PH_RDARR) || (p == PH_RDSTAT);
    endfunction

endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync
    import eep_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sck,
    input  logic    si,
    input  logic    xfer_en,
    output pin_ev_t ev,
    output logic    cs_high
);

    logic [1:0] cs_m, sck_m, si_m;
    logic       cs_q, sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_m  <= '0;
            sck_m <= '0;
            si_m  <= '0;
            cs_q  <= 1'b0;
            sck_q <= 1'b0;
        end else begin
            cs_m  <= {cs_m[0], cs_n};
            sck_m <= {sck_m[0], sck};
            si_m  <= {si_m[0], si};
            cs_q  <= cs_m[1];
            sck_q <= sck_m[1];
        end
    end

    always_comb begin
        ev.cs_fall  = cs_q & ~cs_m[1];
        ev.cs_rise  = ~cs_q & cs_m[1];
        ev.sck_rise = xfer_en & ~cs_m[1] & ~sck_q & sck_m[1];
        ev.sck_fall = xfer_en & ~cs_m[1] & sck_q & ~sck_m[1];
        ev.si       = si_m[1];
    end

    assign cs_high = cs_m[1];

endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
    parameter int unsigned CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            left <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                left <= CW'(CYCLES - 1);
            end
        end else if (left == '0) begin
            busy <= 1'b0;
        end else begin
            left <= left - 1'b1;
        end
    end

    assign done = busy && (left == '0);

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned PAGE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     put,
    input  logic [PAGE_W-1:0]        put_off,
    input  logic [7:0]               put_data,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned PG    = 1 << PAGE_W;

    logic [7:0]    mem  [DEPTH];
    logic [7:0]    pbuf [PG];
    logic [PG-1:0] pmask;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pmask <= '0;
        end else if (put) begin
            pmask[put_off] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (put) begin
            pbuf[put_off] <= put_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) begin
                mem[ADDR_W'(j)] <= 8'hFF;
            end
        end else if (commit) begin
            for (int i = 0; i < PG; i++) begin
                if (pmask[i]) begin
                    mem[{page, PAGE_W'(i)}] <= pbuf[i];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

    assert_commit_has_data_R6: assert property (@(posedge clk) disable iff (rst)
        commit |-> (pmask != '0));

endmodule

// File: rtl/eep_spi_slave.sv
module eep_spi_slave
    import eep_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned PAGE_W    = 5,
    parameter int unsigned WC_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic xfer_en,
    input  logic sr_wr_ok,
    input  logic arr_wr_ok,
    output logic so,
    output logic so_oe
);

    localparam int unsigned PGN_W = ADDR_W - PAGE_W;

    pin_ev_t ev;
    logic    cs_high;

    phase_e              ph;
    logic                active;
    logic [2:0]          bcnt;
    logic [2:0]          ocnt;
    logic [6:0]          ish;
    logic [ADDR_W-1:0]   ash;
    logic                addr_hi_done;
    logic                is_wr;
    logic [ADDR_W-1:0]   ptr;
    logic [PAGE_W-1:0]   woff;
    logic                got_data;
    cfg_t                sr_new;
    cfg_t                cfg;
    logic                wel;
    job_e                job;
    logic [PGN_W-1:0]    wpage;
    logic                so_q;

    logic                busy, done;
    logic [7:0]          rd_data;
    logic [7:0]          new_byte, out_byte;
    logic [ADDR_W-1:0]   addr_full;
    logic                byte_done, wr_go, wren_go, wrdi, put, clr;

    eep_pin_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .sck     (sck),
        .si      (si),
        .xfer_en (xfer_en),
        .ev      (ev),
        .cs_high (cs_high)
    );

    eep_wtimer #(.CYCLES(WC_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (wr_go),
        .busy  (busy),
        .done  (done)
    );

    eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .put      (put),
        .put_off  (woff),
        .put_data (new_byte),
        .commit   (done && (job == JOB_ARRAY)),
        .page     (wpage),
        .rd_addr  (ptr),
        .rd_data  (rd_data)
    );

    always_comb begin
        new_byte  = {ish, ev.si};
        addr_full = {ash[ADDR_W-2:0], ev.si};
        byte_done = active && ev.sck_rise && (bcnt == 3'd7);
        out_byte  = (ph == PH_RDARR) ? rd_data : status_byte(cfg, wel, busy);
        wr_go     = ev.cs_rise && active && (bcnt == 3'd0) && got_data && wel &&
                    (((ph == PH_WRARR) && arr_wr_ok) || ((ph == PH_WRSTAT) && sr_wr_ok));
        wren_go   = ev.cs_rise && active && (ph == PH_WENDONE);
        wrdi      = byte_done && (ph == PH_OPCODE) && !busy && (new_byte == OP_WRDI);
        put       = byte_done && (ph == PH_WRARR);
        clr       = byte_done && (ph == PH_ADDR) && addr_hi_done && is_wr;
    end

    // serial command engine
    always_ff @(posedge clk) begin
        if (rst) begin
            active       <= 1'b0;
            ph           <= PH_OPCODE;
            bcnt         <= '0;
            ocnt         <= '0;
            ish          <= '0;
            ash          <= '0;
            addr_hi_done <= 1'b0;
            is_wr        <= 1'b0;
            ptr          <= '0;
            woff         <= '0;
            got_data     <= 1'b0;
            sr_new       <= '0;
            so_q         <= 1'b0;
        end else if (ev.cs_fall) begin
            active   <= 1'b1;
            ph       <= PH_OPCODE;
            bcnt     <= '0;
            ocnt     <= '0;
            got_data <= 1'b0;
        end else if (ev.cs_rise) begin
            active <= 1'b0;
            ph     <= PH_OPCODE;
            bcnt   <= '0;
            ocnt   <= '0;
        end else if (active) begin
            if (ev.sck_rise) begin
                bcnt <= bcnt + 1'b1;
                ish  <= new_byte[6:0];
                case (ph)
                    PH_OPCODE: if (byte_done) begin
                        if (busy && new_byte != OP_RDSR) begin
                            ph <= PH_SKIP;
                        end else begin
                            case (new_byte)
                                OP_WREN:  ph <= PH_WENDONE;
                                OP_RDSR:  ph <= PH_RDSTAT;
                                OP_WRSR:  begin ph <= PH_WRSTAT; got_data <= 1'b0; end
                                OP_READ:  begin ph <= PH_ADDR; is_wr <= 1'b0; addr_hi_done <= 1'b0; end
                                OP_WRITE: begin ph <= PH_ADDR; is_wr <= 1'b1; addr_hi_done <= 1'b0; end
                                default:  ph <= PH_SKIP;
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        ash <= addr_full;
                        if (byte_done) begin
                            if (!addr_hi_done) begin
                                addr_hi_done <= 1'b1;
                            end else begin
                                ptr      <= addr_full;
                                woff     <= addr_full[PAGE_W-1:0];
                                got_data <= 1'b0;
                                ph       <= is_wr ? PH_WRARR : PH_RDARR;
                            end
                        end
                    end
                    PH_WRARR: if (byte_done) begin
                        woff     <= woff + 1'b1;
                        got_data <= 1'b1;
                    end
                    PH_WRSTAT: if (byte_done) begin
                        sr_new   <= '{lock_en: new_byte[7], prot: new_byte[3:2]};
                        got_data <= 1'b1;
                    end
                    PH_WENDONE: ph <= PH_SKIP;
                    default: ;
                endcase
            end
            if (ev.sck_fall && is_read_phase(ph)) begin
                so_q <= out_byte[3'd7 - ocnt];
                ocnt <= ocnt + 1'b1;
                if ((ocnt == 3'd7) && (ph == PH_RDARR)) begin
                    ptr <= ptr + 1'b1;
                end
            end
        end
    end

    // permission latch, configuration and job bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            wel   <= 1'b0;
            cfg   <= '0;
            job   <= JOB_ARRAY;
            wpage <= '0;
        end else begin
            if (wr_go) begin
                job   <= (ph == PH_WRSTAT) ? JOB_STATUS : JOB_ARRAY;
                wpage <= ptr[ADDR_W-1:PAGE_W];
            end
            if (done) begin
                wel <= 1'b0;
                if (job == JOB_STATUS) begin
                    cfg <= sr_new;
                end
            end else if (wren_go) begin
                wel <= 1'b1;
            end else if (wrdi) begin
                wel <= 1'b0;
            end
        end
    end

    assign so_oe = active && xfer_en && !cs_high && is_read_phase(ph);
    assign so    = so_oe ? so_q : 1'b0;

    assert_wel_drop_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !wel);

    assert_busy_after_go_R6: assert property (@(posedge clk) disable iff (rst)
        wr_go |=> busy);

    assert_busy_phase_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ph == PH_OPCODE || ph == PH_RDSTAT || ph == PH_SKIP));

    assert_pause_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        (!xfer_en && !ev.cs_rise && !ev.cs_fall) |=> ($stable(bcnt) && $stable(so_q)));

endmodule

// File: tb/eep_spi_slave_bench.sv
module eep_spi_slave_bench;

    localparam int AW   = 8;
    localparam int PW   = 3;
    localparam int WC   = 1500;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b0;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic xfer_en = 1'b1;
    logic sr_wr_ok = 1'b1;
    logic arr_wr_ok = 1'b1;
    logic so, so_oe;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] rbuf [16];
    logic [7:0] rx;

    // write address, read address, data, array enable, expected readback
    localparam logic [15:0] V_WA  [6] = '{16'h0005, 16'hFF12, 16'h0040, 16'h00FF, 16'h0020, 16'h0005};
    localparam logic [15:0] V_RA  [6] = '{16'h0005, 16'h0012, 16'h0040, 16'h00FF, 16'h0020, 16'h0005};
    localparam logic [7:0]  V_D   [6] = '{8'hA5, 8'h3C, 8'h77, 8'h81, 8'h00, 8'h5A};
    localparam logic        V_OK  [6] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam logic [7:0]  V_EXP [6] = '{8'hA5, 8'h3C, 8'hFF, 8'h81, 8'h00, 8'h5A};

    always #4 clk = ~clk;

    eep_spi_slave #(.ADDR_W(AW), .PAGE_W(PW), .WC_CYCLES(WC)) u_eep_spi_slave (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .xfer_en(xfer_en),
        .sr_wr_ok(sr_wr_ok), .arr_wr_ok(arr_wr_ok), .so(so), .so_oe(so_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] r);
        r = '0;
        for (int k = 0; k < n; k++) begin
            si = tx[7-k];
            tick(HALF);
            r = {r[6:0], so};
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic sel;
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic desel;
        tick(HALF);
        cs_n = 1'b1;
        tick(2*HALF);
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] d;
        sel();
        bits(op, 8, d);
        desel();
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] d;
        sel();
        bits(8'h05, 8, d);
        bits(8'h00, 8, st);
        desel();
    endtask

    task automatic rd(input logic [15:0] a, input int n);
        logic [7:0] d;
        sel();
        bits(8'h03, 8, d);
        bits(a[15:8], 8, d);
        bits(a[7:0], 8, d);
        for (int k = 0; k < n; k++) bits(8'h00, 8, rbuf[k]);
        desel();
    endtask

    task automatic wr1(input logic [15:0] a, input logic [7:0] v);
        logic [7:0] d;
        sel();
        bits(8'h02, 8, d);
        bits(a[15:8], 8, d);
        bits(a[7:0], 8, d);
        bits(v, 8, d);
        desel();
    endtask

    task automatic wsr(input logic [7:0] v);
        logic [7:0] d;
        sel();
        bits(8'h01, 8, d);
        bits(v, 8, d);
        desel();
    endtask

    initial begin
        tick(150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d, st, r1, r2;
        // R1: select held low through reset, command must be ignored
        tick(5);
        rst = 1'b0;
        tick(5);
        chk("R1 oe after reset", so_oe, 1'b0);
        bits(8'h06, 8, d);
        chk("R1 oe without select edge", so_oe, 1'b0);
        desel();
        rdsr(st);
        chk("R1 status after reset", st, 8'h00);
        rd(16'h0010, 1);
        chk("R1 erased array", rbuf[0], 8'hFF);

        // table walk: R4 address use, R7 latch, R10 array enable
        for (int v = 0; v < 6; v++) begin
            arr_wr_ok = V_OK[v];
            op1(8'h06);
            wr1(V_WA[v], V_D[v]);
            tick(WC + 50);
            rd(V_RA[v], 1);
            chk(V_OK[v] ? "R4 table readback" : "R10 blocked write", rbuf[0], V_EXP[v]);
        end
        arr_wr_ok = 1'b1;
        rdsr(st);
        chk("R7 latch cleared after cycle", st, 8'h00);

        // R3 permission latch
        op1(8'h06);
        rdsr(st);
        chk("R3 set permission", st, 8'h02);
        op1(8'h04);
        rdsr(st);
        chk("R3 clear permission", st, 8'h00);
        sel(); bits(8'h06, 8, d); bits(8'h00, 8, d); desel();
        rdsr(st);
        chk("R3 permission needs select at bit 8", st, 8'h00);

        // R4 wrap from top of array and mode 3
        rd(16'h00FF, 2);
        chk("R4 byte at top", rbuf[0], 8'h81);
        chk("R4 wrap to zero", rbuf[1], 8'hFF);
        sck = 1'b1; tick(HALF);
        cs_n = 1'b0; tick(HALF);
        sck = 1'b0;
        bits(8'h03, 8, d); bits(8'h00, 8, d); bits(8'h12, 8, d);
        bits(8'h00, 8, r1);
        tick(HALF); sck = 1'b1; tick(HALF);
        cs_n = 1'b1; tick(2*HALF);
        sck = 1'b0; tick(HALF);
        chk("R4 mode 3 read", r1, 8'h3C);

        // R5 page wrap, R8 busy window
        op1(8'h06);
        sel();
        bits(8'h02, 8, d); bits(8'h00, 8, d); bits(8'h36, 8, d);
        for (int k = 0; k < 10; k++) bits(8'h90 + 8'(k), 8, d);
        desel();
        rdsr(st);
        chk("R8 busy visible in status", st, 8'h03);
        wr1(16'h0050, 8'h11);
        tick(WC + 50);
        rdsr(st);
        chk("R7 latch cleared after page write", st, 8'h00);
        rd(16'h0050, 1);
        chk("R8 write during busy ignored", rbuf[0], 8'hFF);
        rd(16'h0030, 9);
        for (int k = 0; k < 6; k++) chk("R5 page wrap body", rbuf[k], 8'h92 + 8'(k));
        chk("R5 overwritten head", rbuf[6], 8'h98);
        chk("R5 overwritten next", rbuf[7], 8'h99);
        chk("R5 next page untouched", rbuf[8], 8'hFF);

        // R6 aborted writes
        op1(8'h06);
        sel(); bits(8'h02, 8, d); bits(8'h00, 8, d); bits(8'h60, 8, d);
        bits(8'h42, 8, d); bits(8'hF0, 4, d); desel();
        rdsr(st);
        chk("R6 mid-byte select keeps latch, no cycle", st, 8'h02);
        sel(); bits(8'h02, 8, d); bits(8'h00, 8, d); bits(8'h60, 8, d); desel();
        rdsr(st);
        chk("R6 no data byte, no cycle", st, 8'h02);
        rd(16'h0060, 1);
        chk("R6 array untouched", rbuf[0], 8'hFF);

        // R7 write without permission
        op1(8'h04);
        wr1(16'h0061, 8'h24);
        tick(50);
        rd(16'h0061, 1);
        chk("R7 write without permission", rbuf[0], 8'hFF);

        // R9 status write
        op1(8'h06);
        wsr(8'hFF);
        tick(WC + 50);
        rdsr(st);
        chk("R9 status write keeps bits 7,3,2", st, 8'h8C);
        sr_wr_ok = 1'b0;
        op1(8'h06);
        wsr(8'h00);
        tick(50);
        rdsr(st);
        chk("R9 refused status write", st, 8'h8E);
        sr_wr_ok = 1'b1;
        wsr(8'h04);
        tick(WC + 50);
        rdsr(st);
        chk("R9 second status write", st, 8'h04);

        // R2 unknown code swallows transaction
        sel(); bits(8'hAB, 8, d); bits(8'h06, 8, d); desel();
        rdsr(st);
        chk("R2 unknown code ignored", st, 8'h04);

        // R11 pause and R12 enable during read
        chk("R12 oe low while deselected", so_oe, 1'b0);
        sel();
        bits(8'h03, 8, d); bits(8'h00, 8, d); bits(8'h05, 8, d);
        bits(8'h00, 4, r1);
        tick(HALF);
        chk("R12 oe high in read data", so_oe, 1'b1);
        xfer_en = 1'b0;
        tick(2);
        chk("R11 oe low in pause", so_oe, 1'b0);
        for (int k = 0; k < 3; k++) begin
            sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        end
        xfer_en = 1'b1;
        tick(HALF);
        bits(8'h00, 4, r2);
        desel();
        chk("R11 resumed byte", {r1[3:0], r2[3:0]}, 8'h5A);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule